// File: doc/BRIEF.md
# Framebuffer Control and Status Registers

This block is the small register file that sits beside the scanout engine of a simple framebuffer controller. It decodes a 32-byte window. In that window it keeps one control byte, whose top bit enables a once-per-frame interrupt, and one status byte. The status byte reports a pending-interrupt flag together with fixed identification bits for the attached monitor and for a colour board. It also holds a bank of general byte registers, which the rest of the controller uses for cursor limits and video control.

The scanout logic sends a one-cycle `frame_done` pulse at the end of each frame. If the interrupt is enabled, the pulse latches the pending flag, and the flag drives a level interrupt line. Software acknowledges the interrupt by writing any value to the status byte. The lower sixteen offsets belong to palette logic that lives elsewhere. Here they read as zero, and writes to them are dropped.

Top module: `fbreg_top`

## Requirements
- R1: After reset `irq` is 0, the control byte (offset 0x10) reads 0x00, the status byte (offset 0x11) reads 0x61, and every other offset reads 0x00.
- R2: Offset 0x10 is a full 8-bit read/write register. A write with `wr_en` high stores `wr_data`, and a later read returns it.
- R3: A read of offset 0x11 returns 0x61 ORed with the pending flag placed in bit 7. Bits 6:5 are always 1 (monitor identity), bit 0 is always 1 (colour board), and bits 4:1 are always 0.
- R4: A `frame_done` pulse while control bit 7 is 1 sets the pending flag, and `irq` is 1 after that clock edge.
- R5: A `frame_done` pulse while control bit 7 is 0 leaves the pending flag and `irq` unchanged.
- R6: A write of any value to offset 0x11 clears the pending flag, and `irq` is 0 after that edge. The written data is not stored.
- R7: When a status write and an enabled `frame_done` fall in the same cycle, the pending flag is 1 after the edge.
- R8: Offsets 0x12 through 0x1F are fourteen independent 8-bit read/write registers.
- R9: Offsets 0x00 through 0x0F read as 0x00, and writes to them change no other register.
- R10: `irq` always equals the pending flag. Clearing control bit 7 does not drop a flag that is already pending.
- R11: `rd_data` is registered. It shows the value at `addr` one cycle after a cycle with `rd_en` high, and it holds its value in cycles with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset within the register window |
| wr_en | input | 1 | Write strobe for `addr` |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe for `addr` |
| rd_data | output | 8 | Registered read data |
| frame_done | input | 1 | One-cycle end-of-frame pulse from scanout |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
A corrupted pending flag appears in two places at once. It shows on `irq` one cycle after the faulty edge, and it shows in bit 7 of the next status read, so the two observations must agree at every check. A decode fault moves a byte to a neighbouring offset. The full-window sweeps expose this on the first read-back after the write, because every offset holds a distinct value. A wrong priority between acknowledge and frame pulse shows as `irq` low in the single cycle after the coincident event.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;
  localparam int unsigned FB_ADDR_W     = 5;
  localparam int unsigned FB_DATA_W     = 8;
  localparam int unsigned FB_CTRL_OFS   = 16;
  localparam int unsigned FB_STAT_OFS   = 17;
  localparam int unsigned FB_STORE_BASE = 18;
  localparam int unsigned FB_IRQEN_BIT  = 7;
  localparam int unsigned FB_PEND_BIT   = 7;
  localparam logic [7:0]  FB_STAT_ID    = 8'h61;
endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode #(
  parameter int unsigned ADDR_W     = fbreg_pkg::FB_ADDR_W,
  parameter int unsigned CTRL_OFS   = fbreg_pkg::FB_CTRL_OFS,
  parameter int unsigned STAT_OFS   = fbreg_pkg::FB_STAT_OFS,
  parameter int unsigned STORE_BASE = fbreg_pkg::FB_STORE_BASE,
  parameter int unsigned STORE_CNT  = (1 << ADDR_W) - STORE_BASE,
  parameter int unsigned IDX_W      = (STORE_CNT > 1) ? $clog2(STORE_CNT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_hit,
  output logic              stat_hit,
  output logic              store_hit,
  output logic [IDX_W-1:0]  store_idx
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] STORE_A = ADDR_W'(STORE_BASE);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    ctrl_hit  = (addr == CTRL_A);
    stat_hit  = (addr == STAT_A);
    store_hit = (addr >= STORE_A);
    rel       = addr - STORE_A;
    store_idx = store_hit ? rel[IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/fbreg_ctrl_stat.sv
module fbreg_ctrl_stat #(
  parameter int unsigned DATA_W    = fbreg_pkg::FB_DATA_W,
  parameter int unsigned IRQEN_BIT = fbreg_pkg::FB_IRQEN_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_done,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pend_q,
  output logic              irq_q
);
  logic              ctrl_en;
  logic [DATA_W-1:0] ctrl_d;
  logic              pend_set;
  logic              pend_d;

  always_comb begin
    ctrl_en  = ctrl_wr;
    ctrl_d   = wdata;
    pend_set = frame_done & ctrl_q[IRQEN_BIT];
    // set beats acknowledge so a coincident frame is not lost
    pend_d   = pend_set | (pend_q & ~stat_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d;
    end
  end

  // R4
  frame_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ctrl_q[IRQEN_BIT]) |=> pend_q);
  // R5
  disabled_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ctrl_q[IRQEN_BIT] && !stat_wr) |=> $stable(pend_q));
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !(frame_done && ctrl_q[IRQEN_BIT])) |=> !pend_q && !irq_q);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && frame_done && ctrl_q[IRQEN_BIT]) |=> irq_q);
  // R10
  irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == pend_q);
endmodule

// File: rtl/fbreg_store.sv
module fbreg_store #(
  parameter int unsigned DATA_W = fbreg_pkg::FB_DATA_W,
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic cell_en;
    always_comb cell_en = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[gi] <= '0;
      end else if (cell_en) begin
        cell_q[gi] <= wdata;
      end
    end

    // R8
    cell_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(gi)) |=> cell_q[gi] == $past(wdata));
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (rd_idx == IDX_W'(k)) rd_val = cell_q[k];
    end
  end
endmodule

// File: rtl/fbreg_top.sv
module fbreg_top #(
  parameter int unsigned ADDR_W     = fbreg_pkg::FB_ADDR_W,
  parameter int unsigned DATA_W     = fbreg_pkg::FB_DATA_W,
  parameter int unsigned CTRL_OFS   = fbreg_pkg::FB_CTRL_OFS,
  parameter int unsigned STAT_OFS   = fbreg_pkg::FB_STAT_OFS,
  parameter int unsigned STORE_BASE = fbreg_pkg::FB_STORE_BASE,
  parameter int unsigned IRQEN_BIT  = fbreg_pkg::FB_IRQEN_BIT,
  parameter int unsigned PEND_BIT   = fbreg_pkg::FB_PEND_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              frame_done,
  output logic              irq
);
  localparam int unsigned STORE_CNT = (1 << ADDR_W) - STORE_BASE;
  localparam int unsigned IDX_W     = (STORE_CNT > 1) ? $clog2(STORE_CNT) : 1;
  localparam logic [DATA_W-1:0] STAT_ID = DATA_W'(fbreg_pkg::FB_STAT_ID);

  logic              ctrl_hit, stat_hit, store_hit;
  logic [IDX_W-1:0]  store_idx;
  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic              irq_q;
  logic [DATA_W-1:0] store_val;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic              rd_load;

  fbreg_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
    .STORE_BASE(STORE_BASE), .STORE_CNT(STORE_CNT), .IDX_W(IDX_W)
  ) i_decode (
    .addr(addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit),
    .store_hit(store_hit), .store_idx(store_idx)
  );

  fbreg_ctrl_stat #(.DATA_W(DATA_W), .IRQEN_BIT(IRQEN_BIT)) i_ctrl_stat (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_en && ctrl_hit), .stat_wr(wr_en && stat_hit),
    .wdata(wr_data), .frame_done(frame_done),
    .ctrl_q(ctrl_q), .pend_q(pend_q), .irq_q(irq_q)
  );

  fbreg_store #(.DATA_W(DATA_W), .DEPTH(STORE_CNT), .IDX_W(IDX_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && store_hit), .wr_idx(store_idx), .wdata(wr_data),
    .rd_idx(store_idx), .rd_val(store_val)
  );

  always_comb begin
    rd_load = rd_en;
    rd_d    = '0;
    if (ctrl_hit) begin
      rd_d = ctrl_q;
    end else if (stat_hit) begin
      rd_d           = STAT_ID;
      rd_d[PEND_BIT] = pend_q;
    end else if (store_hit) begin
      rd_d = store_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_load) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R3
  stat_id_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(STAT_OFS)) |=> rd_data[6:0] == 7'h61);
  // R9
  low_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr < ADDR_W'(CTRL_OFS)) |=> rd_data == '0);
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R10
  stat_irq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(STAT_OFS) && !wr_en && !frame_done)
      |=> rd_data[PEND_BIT] == irq);
endmodule

// File: tb/test_fbreg_top.sv
module test_fbreg_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       frame_done;
  logic       irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_ctrl;
  logic       m_pend;
  logic [7:0] m_store [32];

  always #4 clk = ~clk;

  fbreg_top i_fbreg_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .frame_done(frame_done), .irq(irq)
  );

  function automatic logic [7:0] exp_val(input logic [4:0] a);
    if (a == 5'h10) return m_ctrl;
    if (a == 5'h11) return 8'h61 | {m_pend, 7'd0};
    if (a >= 5'h12) return m_store[a];
    return 8'h00;
  endfunction

  function automatic string req_of(input logic [4:0] a);
    if (a < 5'h10) return "R9";
    if (a == 5'h10) return "R2";
    if (a == 5'h11) return "R3";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 5'h10) m_ctrl = d;
    else if (a == 5'h11) m_pend = 1'b0;
    else if (a >= 5'h12) m_store[a] = d;
  endtask

  task automatic do_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    if (m_ctrl[7]) m_pend = 1'b1;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] d;
    for (int a = 0; a < 32; a++) begin
      do_rd(5'(a), d);
      check(a == 0 ? tag : req_of(5'(a)), d, exp_val(5'(a)));
    end
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; frame_done = 1'b0;
    m_ctrl = '0; m_pend = 1'b0;
    for (int a = 0; a < 32; a++) m_store[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across the window
    check("R1", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 32; a++) begin
      do_rd(5'(a), d);
      check("R1", d, exp_val(5'(a)));
    end

    // R2 R8 R9: distinct patterns written to every offset
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 32; a++) do_wr(5'(a), 8'((a * 29 + p * 83 + 17) & 255));
      sweep("R9");
      check("R5", {7'd0, irq}, 8'h00);
    end

    // R5: frame with enable clear
    do_wr(5'h10, 8'h7F);
    pulse_frame();
    check("R5", {7'd0, irq}, 8'h00);
    do_rd(5'h11, d); check("R5", d, 8'h61);

    // R4 R3 R10: enabled frame
    do_wr(5'h10, 8'h80);
    pulse_frame();
    check("R4", {7'd0, irq}, 8'h01);
    do_rd(5'h11, d); check("R3", d, 8'hE1);

    // R6: acknowledge with zero data
    do_wr(5'h11, 8'h00);
    check("R6", {7'd0, irq}, 8'h00);
    do_rd(5'h11, d); check("R6", d, 8'h61);

    // R6: acknowledge with all-ones data
    pulse_frame();
    check("R4", {7'd0, irq}, 8'h01);
    do_wr(5'h11, 8'hFF);
    check("R6", {7'd0, irq}, 8'h00);
    do_rd(5'h11, d); check("R6", d, 8'h61);
    do_rd(5'h10, d); check("R2", d, 8'h80);

    // R7: coincident ack and frame, first with flag clear
    @(negedge clk);
    addr = 5'h11; wr_data = 8'h55; wr_en = 1'b1; frame_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame_done = 1'b0; m_pend = 1'b1;
    check("R7", {7'd0, irq}, 8'h01);
    // R7: coincident again with flag already set
    @(negedge clk);
    addr = 5'h11; wr_en = 1'b1; frame_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame_done = 1'b0;
    check("R7", {7'd0, irq}, 8'h01);
    do_rd(5'h11, d); check("R7", d, 8'hE1);

    // R10: disabling keeps a pending flag
    do_wr(5'h10, 8'h00);
    check("R10", {7'd0, irq}, 8'h01);
    do_rd(5'h11, d); check("R10", d, 8'hE1);
    pulse_frame();
    check("R10", {7'd0, irq}, 8'h01);
    do_wr(5'h11, 8'h12);
    check("R10", {7'd0, irq}, 8'h00);

    // R9: writes to low offsets leave everything else intact
    for (int a = 0; a < 16; a++) do_wr(5'(a), 8'hC3);
    sweep("R9");

    // R11: read data holds while rd_en is low
    do_rd(5'h15, held);
    check("R11", held, m_store[5'h15]);
    do_wr(5'h15, ~held);
    check("R11", rd_data, held);
    @(negedge clk); addr = 5'h10;
    @(negedge clk);
    check("R11", rd_data, held);
    do_rd(5'h15, d); check("R11", d, ~held);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule